// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block turns single byte-wide bus writes into operation requests for the embedded program/erase engine of a parallel flash array. Every command opens with a two-write unlock key. The third write picks the command. Program takes a fourth write that carries the target address and byte. Erase takes a second unlock key and a final write that selects either the whole array or one sector. Any write that breaks a sequence drops the decoder back to plain read mode and starts nothing.

Once an operation is running, the decoder follows its state. Byte program and whole-array erase lock out all writes until the engine reports completion. A sector erase can be paused and continued any number of times. While paused, only the continue code is honoured. The hardware reset input aborts everything and restores read mode.

Every request leaves as a one-cycle pulse with an operation code. The program address and byte and the sector number are held on their outputs until the next request of the same kind. A two-bit mode output tells the host which state the part is in.

Top module: `flash_cmd_decoder`

## Requirements
- R1: The unlock key is AAh written to address 555h, then 55h written to address 2AAh. Only address bits 10:0 are compared. A wrong address, wrong byte or wrong order at any step of a sequence returns mode to read (0) and raises no request.
- R2: F0h written as the first write at any address, or as the third write at 555h, pulses a request of kind reset (7) and leaves mode read (0).
- R3: A third write of 90h at 555h pulses a request of kind autoselect (6) and sets mode autoselect (1). A later F0h returns mode to read.
- R4: A third write of A0h at 555h, followed by a fourth write at any address, pulses a request of kind program (1) in the cycle after the fourth write. That fourth write's address and byte appear on the program outputs, and mode becomes busy (2).
- R5: While a byte program or a whole-array erase is busy, every write is ignored: no request, mode stays busy. A done pulse returns mode to read.
- R6: The erase sequence is key, 80h at 555h, key, then 10h at 555h. It pulses a request of kind chip erase (2) and sets mode busy.
- R7: The same erase sequence ending in 30h at any address pulses kind sector erase (3) and drives address bits 17:13 of that write onto the sector output. Further 30h writes during that erase raise no request and leave the sector output unchanged.
- R8: During a sector erase, B0h at any address pulses kind suspend (4) and sets mode suspended (3). Repeated B0h writes are ignored.
- R9: While suspended, 30h at any address pulses kind resume (5) and returns mode to busy. Every other write, and a done pulse, is ignored. Suspend and resume may alternate repeatedly.
- R10: In the final erase step, any write other than 10h at 555h or 30h returns mode to read and raises no request.
- R11: While the active-low reset is asserted, mode is read and no request is raised. After release, a partial sequence from before the reset counts for nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low hardware reset, aborts any operation |
| wrStb | input | 1 | One-cycle bus write strobe, already synchronized |
| wrAddr | input | 18 | Latched write address |
| wrData | input | 8 | Latched write byte |
| opDone | input | 1 | One-cycle completion pulse from the embedded engine |
| opReq | output | 1 | One-cycle operation request |
| opKind | output | 3 | Request kind: 1 program, 2 chip erase, 3 sector erase, 4 suspend, 5 resume, 6 autoselect, 7 reset |
| progAddr | output | 18 | Address of the last program request |
| progData | output | 8 | Byte of the last program request |
| sectAddr | output | 5 | Sector number of the last sector erase request |
| mode | output | 2 | 0 read, 1 autoselect, 2 busy, 3 erase suspended |

## Verification
A wrong sequence state is visible only at the end of a command. A step that advanced on a bad write, or failed to advance on a good one, shows up on the write that should have completed the command: a request is missing, appears early, or has the wrong kind. The scenarios therefore always finish a sequence and check the request one cycle after the last write. A wrong mode or busy-kind register shows up on the very next write during an operation. Such a write raises a suspend or resume request that should have been ignored, or drops one that should have been raised. It also shows up as a mode value that disagrees with the sequence of requests and done pulses so far.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [1:0] {
    MODE_READ = 2'd0,
    MODE_AUTO = 2'd1,
    MODE_BUSY = 2'd2,
    MODE_SUSP = 2'd3
  } mode_e;

  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_PROG   = 3'd1,
    OP_CHIP   = 3'd2,
    OP_SECT   = 3'd3,
    OP_SUSP   = 3'd4,
    OP_RESUME = 3'd5,
    OP_AUTO   = 3'd6,
    OP_RESET  = 3'd7
  } op_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_KEY2,
    SQ_CMD,
    SQ_PROG,
    SQ_EKEY1,
    SQ_EKEY2,
    SQ_EFIN
  } seq_e;

  typedef struct packed {
    logic issue;
    op_e  kind;
    logic loadProg;
    logic loadSect;
  } strobe_t;

  localparam logic [7:0] CODE_KEY_A   = 8'hAA;
  localparam logic [7:0] CODE_KEY_B   = 8'h55;
  localparam logic [7:0] CODE_PROG    = 8'hA0;
  localparam logic [7:0] CODE_ERASE   = 8'h80;
  localparam logic [7:0] CODE_AUTO    = 8'h90;
  localparam logic [7:0] CODE_RESET   = 8'hF0;
  localparam logic [7:0] CODE_CHIP    = 8'h10;
  localparam logic [7:0] CODE_SECT    = 8'h30;
  localparam logic [7:0] CODE_SUSPEND = 8'hB0;

endpackage

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int KEY_W = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrStb,
  input  logic [KEY_W-1:0] keyAddr,
  input  logic [7:0]       code,
  input  logic             opDone,
  output strobe_t          strobe,
  output mode_e            mode
);

  localparam logic [KEY_W-1:0] ADDR_A = KEY_W'(11'h555);
  localparam logic [KEY_W-1:0] ADDR_B = KEY_W'(11'h2AA);

  seq_e  seq, seqNext;
  mode_e modeNext;
  op_e   busyKind, busyKindNext;

  logic atA, atB;
  assign atA = (keyAddr == ADDR_A);
  assign atB = (keyAddr == ADDR_B);

  always_comb begin
    seqNext      = seq;
    modeNext     = mode;
    busyKindNext = busyKind;
    strobe       = '0;
    if (mode == MODE_BUSY && opDone) begin
      modeNext = MODE_READ;
      seqNext  = SQ_IDLE;
    end else if (wrStb) begin
      unique case (mode)
        MODE_BUSY: begin
          if (busyKind == OP_SECT && code == CODE_SUSPEND) begin
            strobe.issue = 1'b1;
            strobe.kind  = OP_SUSP;
            modeNext     = MODE_SUSP;
          end
        end
        MODE_SUSP: begin
          if (code == CODE_SECT) begin
            strobe.issue = 1'b1;
            strobe.kind  = OP_RESUME;
            modeNext     = MODE_BUSY;
          end
        end
        default: begin
          // any step that does not match falls back to read
          seqNext  = SQ_IDLE;
          modeNext = MODE_READ;
          unique case (seq)
            SQ_IDLE: begin
              if (code == CODE_RESET) begin
                strobe.issue = 1'b1;
                strobe.kind  = OP_RESET;
              end else if (code == CODE_KEY_A && atA) begin
                seqNext  = SQ_KEY2;
                modeNext = mode;
              end
            end
            SQ_KEY2: if (code == CODE_KEY_B && atB) begin
              seqNext  = SQ_CMD;
              modeNext = mode;
            end
            SQ_CMD: if (atA) begin
              if (code == CODE_PROG) begin
                seqNext  = SQ_PROG;
                modeNext = mode;
              end else if (code == CODE_ERASE) begin
                seqNext  = SQ_EKEY1;
                modeNext = mode;
              end else if (code == CODE_AUTO) begin
                strobe.issue = 1'b1;
                strobe.kind  = OP_AUTO;
                modeNext     = MODE_AUTO;
              end else if (code == CODE_RESET) begin
                strobe.issue = 1'b1;
                strobe.kind  = OP_RESET;
              end
            end
            SQ_PROG: begin
              strobe.issue    = 1'b1;
              strobe.kind     = OP_PROG;
              strobe.loadProg = 1'b1;
              modeNext        = MODE_BUSY;
              busyKindNext    = OP_PROG;
            end
            SQ_EKEY1: if (code == CODE_KEY_A && atA) begin
              seqNext  = SQ_EKEY2;
              modeNext = mode;
            end
            SQ_EKEY2: if (code == CODE_KEY_B && atB) begin
              seqNext  = SQ_EFIN;
              modeNext = mode;
            end
            SQ_EFIN: begin
              if (code == CODE_CHIP && atA) begin
                strobe.issue = 1'b1;
                strobe.kind  = OP_CHIP;
                modeNext     = MODE_BUSY;
                busyKindNext = OP_CHIP;
              end else if (code == CODE_SECT) begin
                strobe.issue    = 1'b1;
                strobe.kind     = OP_SECT;
                strobe.loadSect = 1'b1;
                modeNext        = MODE_BUSY;
                busyKindNext    = OP_SECT;
              end
            end
            default: ;
          endcase
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seq      <= SQ_IDLE;
      mode     <= MODE_READ;
      busyKind <= OP_NONE;
    end else begin
      seq      <= seqNext;
      mode     <= modeNext;
      busyKind <= busyKindNext;
    end
  end

endmodule

// File: rtl/flash_cmd_dpath.sv
module flash_cmd_dpath
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W  = 18,
  parameter int DATA_W  = 8,
  parameter int SECT_LO = 13,
  parameter int SECT_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic              opReq,
  output op_e               opKind,
  output logic [ADDR_W-1:0] progAddr,
  output logic [DATA_W-1:0] progData,
  output logic [SECT_W-1:0] sectAddr
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opReq    <= 1'b0;
      opKind   <= OP_NONE;
      progAddr <= '0;
      progData <= '0;
      sectAddr <= '0;
    end else begin
      opReq  <= strobe.issue;
      opKind <= strobe.issue ? strobe.kind : OP_NONE;
      if (strobe.loadProg) begin
        progAddr <= wrAddr;
        progData <= wrData;
      end
      if (strobe.loadSect) sectAddr <= wrAddr[SECT_LO +: SECT_W];
    end
  end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W  = 18,
  parameter int DATA_W  = 8,
  parameter int KEY_W   = 11,
  parameter int SECT_HI = 17,
  parameter int SECT_LO = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              opDone,
  output logic              opReq,
  output logic [2:0]        opKind,
  output logic [ADDR_W-1:0] progAddr,
  output logic [DATA_W-1:0] progData,
  output logic [SECT_HI-SECT_LO:0] sectAddr,
  output logic [1:0]        mode
);

  localparam int SECT_W = SECT_HI - SECT_LO + 1;

  strobe_t strobe;
  mode_e   modeInt;
  op_e     kindInt;

  flash_cmd_ctrl #(.KEY_W(KEY_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrStb   (wrStb),
    .keyAddr (wrAddr[KEY_W-1:0]),
    .code    (wrData[7:0]),
    .opDone  (opDone),
    .strobe  (strobe),
    .mode    (modeInt)
  );

  flash_cmd_dpath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .SECT_LO(SECT_LO),
    .SECT_W (SECT_W)
  ) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .opReq   (opReq),
    .opKind  (kindInt),
    .progAddr(progAddr),
    .progData(progData),
    .sectAddr(sectAddr)
  );

  assign mode   = modeInt;
  assign opKind = kindInt;

endmodule

// File: rtl/flash_cmd_checker.sv
module flash_cmd_checker #(
  parameter int DATA_W = 8,
  parameter int SECT_W = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrStb,
  input logic [DATA_W-1:0] wrData,
  input logic              opDone,
  input logic              opReq,
  input logic [2:0]        opKind,
  input logic [SECT_W-1:0] sectAddr,
  input logic [1:0]        mode
);

  // R4: a program request always coincides with busy mode
  p_prog_busy_r4: assert property (@(posedge clk) disable iff (!rstN)
    (opReq && opKind == 3'd1) |-> mode == 2'd2);

  // R5: busy persists until done, except for a suspend write
  p_busy_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd2 && !opDone && !(wrStb && wrData[7:0] == 8'hB0)) |=> mode == 2'd2);

  // R5: done while busy returns to read
  p_done_read_r5: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd2 && opDone) |=> mode == 2'd0);

  // R7: sector output changes only with a sector erase request
  p_sect_stable_r7: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sectAddr) |-> (opReq && opKind == 3'd3));

  // R8: suspended state is entered only from busy
  p_susp_entry_r8: assert property (@(posedge clk) disable iff (!rstN)
    (mode != 2'd3) ##1 (mode == 2'd3) |-> $past(mode) == 2'd2);

  // R9: only the resume code leaves the suspended state
  p_susp_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd3 && !(wrStb && wrData[7:0] == 8'h30)) |=> mode == 2'd3);

  // R2: a reset request leaves the decoder in read mode
  p_reset_read_r2: assert property (@(posedge clk) disable iff (!rstN)
    (opReq && opKind == 3'd7) |-> mode == 2'd0);

endmodule

bind flash_cmd_decoder flash_cmd_checker #(
  .DATA_W(DATA_W),
  .SECT_W(SECT_W)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .wrStb   (wrStb),
  .wrData  (wrData),
  .opDone  (opDone),
  .opReq   (opReq),
  .opKind  (opKind),
  .sectAddr(sectAddr),
  .mode    (mode)
);

// File: tb/flash_cmd_decoder_test.sv
module flash_cmd_decoder_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrStb = 1'b0;
  logic [17:0] wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic        opDone = 1'b0;
  logic        opReq;
  logic [2:0]  opKind;
  logic [17:0] progAddr;
  logic [7:0]  progData;
  logic [4:0]  sectAddr;
  logic [1:0]  mode;

  int nChecks = 0;
  int nFails  = 0;

  flash_cmd_decoder uut (
    .clk(clk), .rstN(rstN), .wrStb(wrStb), .wrAddr(wrAddr), .wrData(wrData),
    .opDone(opDone), .opReq(opReq), .opKind(opKind), .progAddr(progAddr),
    .progData(progData), .sectAddr(sectAddr), .mode(mode)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one write; request/mode observed in the cycle after the strobe
  task automatic wr(input logic [17:0] a, input logic [7:0] d);
    @(negedge clk);
    wrStb = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrStb = 1'b0;
  endtask

  task automatic expectReq(input string tag, input int kind, input int md);
    if (kind == 0) chk({tag, " req"}, int'(opReq), 0);
    else begin
      chk({tag, " req"}, int'(opReq), 1);
      chk({tag, " kind"}, int'(opKind), kind);
    end
    chk({tag, " mode"}, int'(mode), md);
  endtask

  task automatic key();
    wr(18'h00555, 8'hAA);
    wr(18'h002AA, 8'h55);
  endtask

  task automatic done();
    @(negedge clk); opDone = 1'b1;
    @(negedge clk); opDone = 1'b0;
  endtask

  task automatic t_reset();
    chk("R11 reset mode", int'(mode), 0);
    chk("R11 reset req", int'(opReq), 0);
  endtask

  task automatic t_abort();
    wr(18'h00555, 8'hAA); wr(18'h00123, 8'h55);
    expectReq("R1 bad addr", 0, 0);
    wr(18'h002AA, 8'h55); wr(18'h00555, 8'hA0);
    expectReq("R1 bad order", 0, 0);
    key(); wr(18'h00555, 8'h77);
    expectReq("R1 bad code", 0, 0);
    key(); wr(18'h00555, 8'h90); key(); wr(18'h00444, 8'hA0);
    expectReq("R1 abort exits autoselect", 0, 0);
  endtask

  task automatic t_resetCmd();
    wr(18'h3FFFF, 8'hF0);
    expectReq("R2 single F0", 7, 0);
    key(); wr(18'h00555, 8'hF0);
    expectReq("R2 third F0", 7, 0);
  endtask

  task automatic t_autosel();
    key(); wr(18'h00555, 8'h90);
    expectReq("R3 autoselect", 6, 1);
    wr(18'h00000, 8'hF0);
    expectReq("R3 exit", 7, 0);
  endtask

  task automatic t_program();
    key(); wr(18'h00555, 8'hA0);
    expectReq("R4 setup", 0, 0);
    wr(18'h12345, 8'h5A);
    expectReq("R4 program", 1, 2);
    chk("R4 progAddr", int'(progAddr), 'h12345);
    chk("R4 progData", int'(progData), 'h5A);
    wr(18'h00555, 8'hAA);
    expectReq("R5 ignore key", 0, 2);
    wr(18'h00000, 8'hB0);
    expectReq("R5 ignore suspend", 0, 2);
    done();
    chk("R5 done read", int'(mode), 0);
  endtask

  task automatic eraseSetup();
    key(); wr(18'h00555, 8'h80); key();
  endtask

  task automatic t_chip();
    eraseSetup(); wr(18'h00555, 8'h10);
    expectReq("R6 chip", 2, 2);
    wr(18'h00000, 8'hB0);
    expectReq("R5 chip no suspend", 0, 2);
    done();
    chk("R6 done read", int'(mode), 0);
  endtask

  task automatic t_sector();
    eraseSetup(); wr(18'h2A123, 8'h30);
    expectReq("R7 sector", 3, 2);
    chk("R7 sectAddr", int'(sectAddr), 'h15);
    wr(18'h00000, 8'h30);
    expectReq("R7 extra 30", 0, 2);
    chk("R7 sectAddr held", int'(sectAddr), 'h15);
    wr(18'h00777, 8'hB0);
    expectReq("R8 suspend", 4, 3);
    wr(18'h00000, 8'hB0);
    expectReq("R8 repeat suspend", 0, 3);
    wr(18'h00555, 8'hAA);
    expectReq("R9 ignore key", 0, 3);
    done();
    chk("R9 done ignored", int'(mode), 3);
    wr(18'h01000, 8'h30);
    expectReq("R9 resume", 5, 2);
    wr(18'h00001, 8'hB0);
    expectReq("R9 suspend again", 4, 3);
    wr(18'h00002, 8'h30);
    expectReq("R9 resume again", 5, 2);
    done();
    chk("R7 done read", int'(mode), 0);
  endtask

  task automatic t_badFinal();
    eraseSetup(); wr(18'h00555, 8'h20);
    expectReq("R10 bad final", 0, 0);
    eraseSetup(); wr(18'h00100, 8'h10);
    expectReq("R10 chip wrong addr", 0, 0);
  endtask

  task automatic t_hwReset();
    eraseSetup(); wr(18'h04000, 8'h30);
    expectReq("R11 pre", 3, 2);
    @(negedge clk); rstN = 1'b0;
    @(negedge clk);
    chk("R11 abort mode", int'(mode), 0);
    chk("R11 abort req", int'(opReq), 0);
    rstN = 1'b1;
    key();
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    wr(18'h00555, 8'hA0); wr(18'h00010, 8'h11);
    expectReq("R11 stale key", 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    t_abort();
    t_resetCmd();
    t_autosel();
    t_program();
    t_chip();
    t_sector();
    t_badFinal();
    t_hwReset();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule